// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides when a CAN controller may stop taking part in bus traffic and when it may rejoin. Software or a debugger asks for a halt-style freeze or for a low-power module disable. The sequencer does not act on the request at once. It holds the request until the protocol engine reports a bus position where stopping is harmless and until all internal transfers are quiet. Only then does it gate the receive path, park the transmit line recessive, stop the prescaler or the submodule clocks, and raise the matching acknowledge flag.

Leaving either mode works the other way round. The submodule clocks come back first. The block then watches the sampled receive line on each bit strobe and counts consecutive recessive bits. Normal operation resumes only after a full run of recessive bits has been seen. A dominant bit anywhere in the run restarts the count. Out of reset the block starts in this same resynchronisation step.

While disabled, the register interface stays clocked. Any access aimed at the timer, the error counters or the message buffers is reported as blocked.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the block is resynchronising. In that state prescalerEn=1, rxIgnore=0, txRecessive=1, both clock enables are 1, errCntWrEn=0, notReady=1, freezeAck=0 and lowPowerAck=0.
- R2: A freeze is wanted only when freezeEn=1 and at least one of haltReq or dbgStop is 1. With freezeEn=0, haltReq has no effect on any output.
- R3: From normal operation, a wanted freeze first waits for a safe bus state. busState encodes idle=0, in-frame=1, intermission=2, error-passive=3 and bus-off=4. Every value except 1 is safe. A safe state seen once during the wait is remembered.
- R4: Freeze entry also waits for engineBusy=0. The entry edge comes at the earliest one clock after the request is seen.
- R5: When frozen, prescalerEn=0, rxIgnore=1, txRecessive=1, the clock enables stay 1, notReady=1 and freezeAck=1.
- R6: errCntWrEn is 1 only while frozen.
- R7: When the freeze request drops, freezeAck clears on the next edge. notReady stays 1 and the block resynchronises.
- R8: Resynchronisation ends on the edge of the 11th consecutive bitStrobe with rxSample=1. A strobe with rxSample=0 restarts the count.
- R9: Setting disableReq while frozen moves to disabled on the next edge. lowPowerAck sets, freezeAck clears and both clock enables go to 0.
- R10: From activity, a disable waits for engineBusy=0 and for one of these: busState idle, busState bus-off, or busState intermission with intermIdx=2 on a bitStrobe that samples rxSample=1.
- R11: While disabled, prescalerEn=0, rxIgnore=1, txRecessive=1, errCntWrEn=0, notReady=1 and lowPowerAck=1. accessBlocked=1 exactly when accessValid=1 and accessTarget is 1 (timer), 2 (error counters) or 3 (message buffers).
- R12: Clearing disableReq returns to frozen on the next edge if a freeze is still wanted. Otherwise it starts resynchronisation.
- R13: A disable request takes priority over a freeze request. While disabled, a wanted freeze leaves the outputs at their disabled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| haltReq | input | 1 | Halt control bit |
| freezeEn | input | 1 | Freeze enable control bit |
| disableReq | input | 1 | Module disable control bit |
| dbgStop | input | 1 | Debugger stop request |
| busState | input | 3 | Protocol engine bus state |
| intermIdx | input | INTERM_W | Bit index within intermission |
| rxSample | input | 1 | Sampled Rx level, 1 = recessive |
| bitStrobe | input | 1 | One-cycle bit sample strobe |
| engineBusy | input | 1 | Internal arbitration/matching/move activity |
| accessValid | input | 1 | Register access in progress |
| accessTarget | input | 2 | Access target class |
| prescalerEn | output | 1 | Prescaler run enable |
| rxIgnore | output | 1 | Rx input gated off |
| txRecessive | output | 1 | Tx forced recessive |
| protoClkEn | output | 1 | Protocol submodule clock enable |
| bufClkEn | output | 1 | Buffer manager clock enable |
| errCntWrEn | output | 1 | Error counter write permission |
| notReady | output | 1 | Not-ready flag |
| freezeAck | output | 1 | Freeze acknowledge |
| lowPowerAck | output | 1 | Low-power acknowledge |
| accessBlocked | output | 1 | Access to gated resource refused |

## Verification
Every gating output and flag is registered from the next mode. A decision made from the inputs present before a rising edge is therefore visible just after that edge. A freeze or disable requested from normal operation needs two edges, one into the waiting state and one out of it. Leaving a mode, or a disable taken while frozen, needs one edge. The exception is accessBlocked, which follows the access inputs in the same cycle but depends on the registered low-power flag.

The bench drives inputs on the falling edge. For each cycle it queues the output vector expected after the coming rising edge. A monitor compares each queued vector one nanosecond after that edge, so every check lands in the cycle the latency count gives.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    BUS_IDLE    = 3'd0,
    BUS_FRAME   = 3'd1,
    BUS_INTERM  = 3'd2,
    BUS_ERRPASS = 3'd3,
    BUS_OFF     = 3'd4
  } busState_e;

  typedef enum logic [2:0] {
    M_RUN,
    M_FRZ_WAIT,
    M_FROZEN,
    M_DIS_WAIT,
    M_DISABLED,
    M_RESYNC
  } mode_e;

  typedef enum logic [1:0] {
    TGT_OTHER  = 2'd0,
    TGT_TIMER  = 2'd1,
    TGT_ERRCNT = 2'd2,
    TGT_MSGBUF = 2'd3
  } accTgt_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    mode_e nextMode;
    logic  clrSafe;
    logic  clrRec;
  } seqCmd_t;

  typedef struct packed {
    logic prescalerEn;
    logic rxIgnore;
    logic txRecessive;
    logic protoClkEn;
    logic bufClkEn;
    logic errCntWrEn;
    logic notReady;
    logic freezeAck;
    logic lowPowerAck;
  } gateSet_t;

  function automatic gateSet_t gatesFor(mode_e m);
    gateSet_t g;
    g = '{prescalerEn: 1'b1, rxIgnore: 1'b0, txRecessive: 1'b0,
          protoClkEn: 1'b1, bufClkEn: 1'b1, errCntWrEn: 1'b0,
          notReady: 1'b0, freezeAck: 1'b0, lowPowerAck: 1'b0};
    case (m)
      M_FROZEN: begin
        g.prescalerEn = 1'b0;
        g.rxIgnore    = 1'b1;
        g.txRecessive = 1'b1;
        g.errCntWrEn  = 1'b1;
        g.notReady    = 1'b1;
        g.freezeAck   = 1'b1;
      end
      M_DISABLED: begin
        g.prescalerEn = 1'b0;
        g.rxIgnore    = 1'b1;
        g.txRecessive = 1'b1;
        g.protoClkEn  = 1'b0;
        g.bufClkEn    = 1'b0;
        g.notReady    = 1'b1;
        g.lowPowerAck = 1'b1;
      end
      M_RESYNC: begin
        g.txRecessive = 1'b1;
        g.notReady    = 1'b1;
      end
      default: ;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    haltReq,
  input  logic    freezeEn,
  input  logic    disableReq,
  input  logic    dbgStop,
  input  logic    engineBusy,
  input  logic    safeFrz,
  input  logic    safeDis,
  input  logic    recDone,
  output seqCmd_t cmd
);

  mode_e mode;
  mode_e nextMode;
  logic  freezeWanted;

  assign freezeWanted = freezeEn && (haltReq || dbgStop);

  always_comb begin
    nextMode = mode;
    case (mode)
      M_RUN: begin
        if (disableReq)        nextMode = M_DIS_WAIT;
        else if (freezeWanted) nextMode = M_FRZ_WAIT;
      end
      M_FRZ_WAIT: begin
        if (disableReq)                   nextMode = M_DIS_WAIT;
        else if (!freezeWanted)           nextMode = M_RUN;
        else if (safeFrz && !engineBusy)  nextMode = M_FROZEN;
      end
      M_FROZEN: begin
        if (disableReq)         nextMode = M_DISABLED;
        else if (!freezeWanted) nextMode = M_RESYNC;
      end
      M_DIS_WAIT: begin
        if (!disableReq)                  nextMode = freezeWanted ? M_FRZ_WAIT : M_RUN;
        else if (safeDis && !engineBusy)  nextMode = M_DISABLED;
      end
      M_DISABLED: begin
        if (!disableReq) nextMode = freezeWanted ? M_FROZEN : M_RESYNC;
      end
      M_RESYNC: begin
        if (disableReq) begin
          if (!engineBusy) nextMode = M_DISABLED;
        end else if (freezeWanted) begin
          if (!engineBusy) nextMode = M_FROZEN;
        end else if (recDone) begin
          nextMode = M_RUN;
        end
      end
      default: nextMode = M_RESYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= M_RESYNC;
    else       mode <= nextMode;
  end

  always_comb begin
    cmd.nextMode = nextMode;
    cmd.clrSafe  = (nextMode != mode);
    cmd.clrRec   = (nextMode != M_RESYNC);
  end

  // R4: a freeze taken from the wait state saw the engine quiet
  p_frz_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_FROZEN && $past(mode) == M_FRZ_WAIT) |-> !$past(engineBusy));

  // R2: freeze is never entered without the enable
  p_frz_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_FROZEN && $past(mode) != M_FROZEN) |-> $past(freezeEn));

  // R10: disable from activity needs a safe point and a quiet engine
  p_dis_safe_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_DISABLED && $past(mode) == M_DIS_WAIT) |-> ($past(safeDis) && !$past(engineBusy)));

endmodule

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int RESYNC_BITS = 11,
  parameter int INTERM_W    = 2,
  parameter int INTERM_LAST = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCmd_t             cmd,
  input  logic [2:0]          busState,
  input  logic [INTERM_W-1:0] intermIdx,
  input  logic                rxSample,
  input  logic                bitStrobe,
  input  logic                accessValid,
  input  logic [1:0]          accessTarget,
  output logic                safeFrz,
  output logic                safeDis,
  output logic                recDone,
  output gateSet_t            gates,
  output logic                accessBlocked
);

  localparam int CW = $clog2(RESYNC_BITS + 1);
  localparam logic [CW-1:0] REC_LAST = CW'(RESYNC_BITS - 1);
  localparam logic [INTERM_W-1:0] IDX_LAST = INTERM_W'(INTERM_LAST);

  logic          frzLatch, disLatch;
  logic          frzNow, disNow;
  logic [CW-1:0] recCnt;

  assign frzNow = (busState == BUS_IDLE) || (busState == BUS_INTERM) ||
                  (busState == BUS_ERRPASS) || (busState == BUS_OFF);
  assign disNow = (busState == BUS_IDLE) || (busState == BUS_OFF) ||
                  ((busState == BUS_INTERM) && (intermIdx == IDX_LAST) &&
                   bitStrobe && rxSample);

  assign safeFrz = frzLatch || frzNow;
  assign safeDis = disLatch || disNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frzLatch <= 1'b0;
      disLatch <= 1'b0;
    end else if (cmd.clrSafe) begin
      frzLatch <= 1'b0;
      disLatch <= 1'b0;
    end else begin
      frzLatch <= safeFrz;
      disLatch <= safeDis;
    end
  end

  assign recDone = bitStrobe && rxSample && (recCnt == REC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               recCnt <= '0;
    else if (cmd.clrRec)     recCnt <= '0;
    else if (bitStrobe) begin
      if (!rxSample || recDone) recCnt <= '0;
      else                      recCnt <= recCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gates <= gatesFor(M_RESYNC);
    else       gates <= gatesFor(cmd.nextMode);
  end

  assign accessBlocked = gates.lowPowerAck && accessValid &&
                         (accessTarget != TGT_OTHER);

  // R9: the two acknowledges never overlap
  p_ack_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(gates.freezeAck && gates.lowPowerAck));

  // R6: error counter writes only with freeze acknowledged
  p_errwr_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    gates.errCntWrEn |-> gates.freezeAck);

  // R11: clocks are off whenever low power is acknowledged
  p_clk_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    gates.lowPowerAck |-> (!gates.protoClkEn && !gates.bufClkEn));

  // R8: the run counter stays inside its window
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    recCnt < CW'(RESYNC_BITS));

  // R8: ready returns only on a recessive bit sample
  p_ready_on_rec_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gates.notReady) |-> $past(bitStrobe && rxSample));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RESYNC_BITS = 11,
  parameter int INTERM_W    = 2,
  parameter int INTERM_LAST = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                haltReq,
  input  logic                freezeEn,
  input  logic                disableReq,
  input  logic                dbgStop,
  input  logic [2:0]          busState,
  input  logic [INTERM_W-1:0] intermIdx,
  input  logic                rxSample,
  input  logic                bitStrobe,
  input  logic                engineBusy,
  input  logic                accessValid,
  input  logic [1:0]          accessTarget,
  output logic                prescalerEn,
  output logic                rxIgnore,
  output logic                txRecessive,
  output logic                protoClkEn,
  output logic                bufClkEn,
  output logic                errCntWrEn,
  output logic                notReady,
  output logic                freezeAck,
  output logic                lowPowerAck,
  output logic                accessBlocked
);

  seqCmd_t  cmd;
  gateSet_t gates;
  logic     safeFrz, safeDis, recDone;

  can_mode_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .haltReq    (haltReq),
    .freezeEn   (freezeEn),
    .disableReq (disableReq),
    .dbgStop    (dbgStop),
    .engineBusy (engineBusy),
    .safeFrz    (safeFrz),
    .safeDis    (safeDis),
    .recDone    (recDone),
    .cmd        (cmd)
  );

  can_mode_dp #(
    .RESYNC_BITS (RESYNC_BITS),
    .INTERM_W    (INTERM_W),
    .INTERM_LAST (INTERM_LAST)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .busState      (busState),
    .intermIdx     (intermIdx),
    .rxSample      (rxSample),
    .bitStrobe     (bitStrobe),
    .accessValid   (accessValid),
    .accessTarget  (accessTarget),
    .safeFrz       (safeFrz),
    .safeDis       (safeDis),
    .recDone       (recDone),
    .gates         (gates),
    .accessBlocked (accessBlocked)
  );

  assign prescalerEn = gates.prescalerEn;
  assign rxIgnore    = gates.rxIgnore;
  assign txRecessive = gates.txRecessive;
  assign protoClkEn  = gates.protoClkEn;
  assign bufClkEn    = gates.bufClkEn;
  assign errCntWrEn  = gates.errCntWrEn;
  assign notReady    = gates.notReady;
  assign freezeAck   = gates.freezeAck;
  assign lowPowerAck = gates.lowPowerAck;

endmodule

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       haltReq = 0, freezeEn = 0, disableReq = 0, dbgStop = 0;
  logic [2:0] busState = 3'd0;
  logic [1:0] intermIdx = 2'd0;
  logic       rxSample = 1, bitStrobe = 0, engineBusy = 0, accessValid = 0;
  logic [1:0] accessTarget = 2'd0;
  logic       prescalerEn, rxIgnore, txRecessive, protoClkEn, bufClkEn;
  logic       errCntWrEn, notReady, freezeAck, lowPowerAck, accessBlocked;

  always #2 clk = ~clk;

  can_mode_seq i_can_mode_seq (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .freezeEn(freezeEn),
    .disableReq(disableReq), .dbgStop(dbgStop), .busState(busState),
    .intermIdx(intermIdx), .rxSample(rxSample), .bitStrobe(bitStrobe),
    .engineBusy(engineBusy), .accessValid(accessValid), .accessTarget(accessTarget),
    .prescalerEn(prescalerEn), .rxIgnore(rxIgnore), .txRecessive(txRecessive),
    .protoClkEn(protoClkEn), .bufClkEn(bufClkEn), .errCntWrEn(errCntWrEn),
    .notReady(notReady), .freezeAck(freezeAck), .lowPowerAck(lowPowerAck),
    .accessBlocked(accessBlocked)
  );

  // {prescalerEn,rxIgnore,txRecessive,protoClkEn,bufClkEn,errCntWrEn,notReady,freezeAck,lowPowerAck,accessBlocked}
  localparam logic [9:0] RUNV = 10'b1_0_0_1_1_0_0_0_0_0;
  localparam logic [9:0] FRZV = 10'b0_1_1_1_1_1_1_1_0_0;
  localparam logic [9:0] DISV = 10'b0_1_1_0_0_0_1_0_1_0;
  localparam logic [9:0] DISB = 10'b0_1_1_0_0_0_1_0_1_1;
  localparam logic [9:0] RESV = 10'b1_0_1_1_1_0_1_0_0_0;

  typedef struct {
    string      tag;
    logic [9:0] vec;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  wire logic [9:0] obs = {prescalerEn, rxIgnore, txRecessive, protoClkEn, bufClkEn,
                          errCntWrEn, notReady, freezeAck, lowPowerAck, accessBlocked};

  // monitor: compares each queued expectation just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (obs !== e.vec) begin
          failures++;
          $display("FAIL %s: got %b expected %b", e.tag, obs, e.vec);
        end
      end
    end
  end

  // driver: inputs already set at the falling edge; queue the result of the next rising edge
  task automatic step(input string tag, input logic [9:0] vec);
    expItem_t e;
    e.tag = tag;
    e.vec = vec;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic resyncRun(input string tag);
    bitStrobe = 1; rxSample = 1;
    for (int i = 0; i < 10; i++) step(tag, RESV);
    step(tag, RUNV);
    bitStrobe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    step("R1 reset state", RESV);

    // R8: five recessive, one dominant restarts, then eleven
    bitStrobe = 1; rxSample = 1;
    for (int i = 0; i < 5; i++) step("R8 partial run", RESV);
    rxSample = 0; step("R8 dominant restart", RESV);
    rxSample = 1;
    for (int i = 0; i < 10; i++) step("R8 counting", RESV);
    step("R8 eleventh recessive", RUNV);
    bitStrobe = 0;

    // R2: halt without enable ignored
    haltReq = 1;
    for (int i = 0; i < 3; i++) step("R2 halt without enable", RUNV);

    // R3: enable, but in frame
    freezeEn = 1; busState = 3'd1;
    for (int i = 0; i < 3; i++) step("R3 wait in frame", RUNV);
    // R4: safe intermission seen while busy, then quiet in frame
    busState = 3'd2; engineBusy = 1;
    step("R4 busy blocks", RUNV);
    step("R4 busy blocks", RUNV);
    busState = 3'd1; engineBusy = 0;
    step("R3 remembered safe, R5 frozen", FRZV);
    rxSample = 0; bitStrobe = 1;
    step("R6 frozen errcnt write", FRZV);
    rxSample = 1;
    step("R5 frozen holds", FRZV);
    bitStrobe = 0;

    // R7: leave freeze
    haltReq = 0;
    step("R7 leave freeze", RESV);
    dbgStop = 1;
    step("R2 debugger stop freezes", FRZV);
    dbgStop = 0;
    step("R7 leave after debugger", RESV);
    resyncRun("R8 resync after freeze");

    // R10: disable during activity, intermission third bit
    disableReq = 1; busState = 3'd1;
    step("R10 wait in frame", RUNV);
    busState = 3'd2; intermIdx = 2'd1; bitStrobe = 1; rxSample = 1;
    step("R10 second bit not enough", RUNV);
    intermIdx = 2'd2; rxSample = 0;
    step("R10 third bit dominant", RUNV);
    rxSample = 1;
    step("R10 third bit recessive", DISV);
    bitStrobe = 0; busState = 3'd0;
    accessValid = 1; accessTarget = 2'd2;
    step("R11 errcnt access blocked", DISB);
    accessTarget = 2'd1;
    step("R11 timer access blocked", DISB);
    accessTarget = 2'd0;
    step("R11 other access allowed", DISV);
    accessValid = 0;

    // R12 then R9 then R13
    disableReq = 0; haltReq = 1;
    step("R12 back to freeze", FRZV);
    disableReq = 1;
    step("R9 disable from freeze", DISV);
    step("R13 disable over freeze", DISV);
    disableReq = 0; haltReq = 0;
    step("R12 resync after disable", RESV);
    resyncRun("R8 resync after disable");

    // R10 bus-off with busy engine
    disableReq = 1; busState = 3'd4; engineBusy = 1;
    step("R10 busoff wait", RUNV);
    step("R10 busoff busy", RUNV);
    engineBusy = 0;
    step("R10 busoff quiet", DISV);
    disableReq = 0;
    step("R12 resync", RESV);
    resyncRun("R8 resync");

    // R13: both requests from run
    busState = 3'd0; haltReq = 1; disableReq = 1;
    step("R13 both requested", RUNV);
    step("R13 disable wins", DISV);

    @(posedge clk); #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule